// File: doc/BRIEF.md
# External-Interrupt Line Source Selector

This block is a small memory-mapped configuration peripheral. Its main job is to route general-purpose pin levels onto sixteen external-interrupt lines. Pins arrive as one flat vector that holds nine ports of sixteen pins each. Interrupt line n can only carry pin n of some port. A 4-bit port code decides which port that is. The line outputs are plain level copies of the chosen pin. Edge detection, pending flags and masking are left to the logic that consumes the lines.

Software reaches the block over a simple 32-bit register bus with separate read and write strobes. It decodes a 1 KiB window. Inside that window are four selection registers that hold the port codes and a compensation-control register that stores the full word. There are also two registers, remap and mode, that always read zero and discard writes. Every other offset reads zero and ignores writes.

Top module: `exti_route_cfg`

## Requirements
- R1: After reset every register reads 0x00000000, so every line follows port 0.
- R2: Each selection register (byte offsets 0x08, 0x0C, 0x10, 0x14) stores only bits [15:0] of a write. Bits [31:16] read back as zero.
- R3: Line n takes its 4-bit port code from selection register n/4, bits [(n%4)*4+3 : (n%4)*4]. Line n equals pin_in[code*16+n] combinationally.
- R4: A port code from 9 to 15 drives its line low, whatever the pin levels are.
- R5: A pin on a port that no line's code selects has no effect on any line output.
- R6: The remap register (offset 0x00) and the mode register (offset 0x04) discard writes and always read 0.
- R7: The compensation register (offset 0x20) stores all 32 bits of a write and returns them on read.
- R8: An unmapped offset reads 0, and a write to it changes no register. Unmapped offsets are 0x18, 0x1C, 0x24 to 0x3FC, and any offset whose low two bits are nonzero.
- R9: A new port code reaches the line on the clock edge that captures the write. Before that edge the line still follows the old port.
- R10: bus_rdata is 0 in any cycle where bus_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | Byte offset within the register window |
| bus_wr_en | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 144 | Pin levels, index = port*16 + pin |
| line_out | output | 16 | Interrupt line levels, one per pin number |

## Verification
The in-RTL properties are checked on every clock cycle. They cover these behaviours:
- reserved codes hold their line low (R4)
- selection writes keep only the low half and the upper half reads zero (R2)
- the compensation register changes only when it is written (R7)
- remap, mode, unmapped offsets and idle reads return zero (R6, R8, R10)

Some behaviours only the bench scenarios can show:
- the field position of each line in its register, and forwarding from the right port (R3)
- that unselected ports are ignored (R5)
- the reset image (R1)
- that a code change takes effect exactly at the capturing edge and not before (R9)

// File: rtl/exti_sel_pkg.sv
`timescale 1ns/1ps
package exti_sel_pkg;
  localparam int unsigned OFF_REMAP = 32'h00;
  localparam int unsigned OFF_MODE  = 32'h04;
  localparam int unsigned OFF_SEL0  = 32'h08;
  localparam int unsigned OFF_COMP  = 32'h20;

  typedef enum logic [2:0] {
    RK_REMAP, RK_MODE, RK_SEL, RK_COMP, RK_NONE
  } reg_kind_e;

  // selection register that holds the code of a line
  function automatic int unsigned sel_reg_of(int unsigned line, int unsigned fields);
    return line / fields;
  endfunction

  // low bit of a line's code inside its selection register
  function automatic int unsigned code_lsb_of(int unsigned line, int unsigned fields,
                                              int unsigned code_w);
    return (line % fields) * code_w;
  endfunction

  // flat pin-vector index of a port/pin pair
  function automatic int unsigned pin_index(int unsigned port, int unsigned pin,
                                            int unsigned pins_per_port);
    return port * pins_per_port + pin;
  endfunction
endpackage

// File: rtl/exti_cfg_regs.sv
`timescale 1ns/1ps
module exti_cfg_regs
  import exti_sel_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int NUM_SEL = 4,
  parameter int SEL_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_SEL*SEL_W-1:0] sel_flat
);
  localparam int SIDX_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
  localparam int SEL_END = OFF_SEL0 + 4 * NUM_SEL;

  reg_kind_e         kind;
  logic [SIDX_W-1:0] sel_idx;
  logic [SEL_W-1:0]  sel_q [NUM_SEL];
  logic [DATA_W-1:0] comp_q;
  logic [DATA_W-1:0] rd_mux;

  // decoded bus events, named for the checks below
  logic sel_wr_hit, comp_wr_hit, fixed_rd_hit, none_rd_hit, sel_rd_hit;

  always_comb begin
    kind    = RK_NONE;
    sel_idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFF_REMAP))      kind = RK_REMAP;
      else if (addr == ADDR_W'(OFF_MODE))  kind = RK_MODE;
      else if (addr == ADDR_W'(OFF_COMP))  kind = RK_COMP;
      else if (addr >= ADDR_W'(OFF_SEL0) && addr < ADDR_W'(SEL_END)) begin
        kind    = RK_SEL;
        sel_idx = SIDX_W'((addr - ADDR_W'(OFF_SEL0)) >> 2);
      end
    end
  end

  assign sel_wr_hit   = wr_en && (kind == RK_SEL);
  assign comp_wr_hit  = wr_en && (kind == RK_COMP);
  assign fixed_rd_hit = rd_en && (kind == RK_REMAP || kind == RK_MODE);
  assign none_rd_hit  = rd_en && (kind == RK_NONE);
  assign sel_rd_hit   = rd_en && (kind == RK_SEL);

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sel_q[g] <= '0;
      else if (sel_wr_hit && sel_idx == SIDX_W'(g)) sel_q[g] <= wdata[SEL_W-1:0];
    end
    assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];

    assert_sel_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr_hit && sel_idx == SIDX_W'(g)) |=> sel_q[g] == $past(wdata[SEL_W-1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           comp_q <= '0;
    else if (comp_wr_hit) comp_q <= wdata;
  end

  always_comb begin
    case (kind)
      RK_SEL:  rd_mux = DATA_W'(sel_q[sel_idx]);
      RK_COMP: rd_mux = comp_q;
      default: rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;

  assert_comp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_wr_hit |=> $stable(comp_q));
  assert_comp_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    comp_wr_hit |=> comp_q == $past(wdata));
  assert_fixed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_rd_hit |-> rdata == '0);
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    none_rd_hit |-> rdata == '0);
  assert_sel_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rd_hit |-> rdata[DATA_W-1:SEL_W] == '0);
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: rtl/exti_line_mux.sv
`timescale 1ns/1ps
module exti_line_mux
  import exti_sel_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int NUM_LINES = 16,
  parameter int CODE_W    = 4,
  parameter int SEL_W     = 16,
  parameter int NUM_SEL   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pin_in,
  input  logic [NUM_SEL*SEL_W-1:0]       sel_flat,
  output logic [NUM_LINES-1:0]           line_out
);
  localparam int FIELDS = SEL_W / CODE_W;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int REG_I = sel_reg_of(n, FIELDS);
    localparam int LSB_I = code_lsb_of(n, FIELDS, CODE_W);

    logic [CODE_W-1:0] code;
    logic              code_reserved;
    logic              level;

    assign code          = sel_flat[REG_I*SEL_W + LSB_I +: CODE_W];
    assign code_reserved = {1'b0, code} >= (CODE_W+1)'(NUM_PORTS);

    always_comb begin
      level = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (code == CODE_W'(p)) level = pin_in[pin_index(p, n, NUM_LINES)];
      end
    end

    assign line_out[n] = level;

    assert_reserved_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      code_reserved |-> !line_out[n]);
  end
endmodule

// File: rtl/exti_route_cfg.sv
`timescale 1ns/1ps
module exti_route_cfg #(
  parameter int NUM_PORTS = 9,
  parameter int NUM_LINES = 16,
  parameter int CODE_W    = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr_en,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_rd_en,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0]           line_out
);
  localparam int SEL_W   = 16;
  localparam int FIELDS  = SEL_W / CODE_W;
  localparam int NUM_SEL = (NUM_LINES + FIELDS - 1) / FIELDS;

  logic [NUM_SEL*SEL_W-1:0] sel_flat;

  exti_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
    .wdata(bus_wdata), .rd_en(bus_rd_en), .rdata(bus_rdata), .sel_flat(sel_flat)
  );

  exti_line_mux #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .CODE_W(CODE_W),
    .SEL_W(SEL_W), .NUM_SEL(NUM_SEL)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sel_flat(sel_flat),
    .line_out(line_out)
  );
endmodule

// File: tb/exti_route_cfg_tb.sv
`timescale 1ns/1ps
module exti_route_cfg_tb;
  typedef struct {
    bit          is_line;
    logic [31:0] exp;
    string       rq;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   bus_addr = '0;
  logic         bus_wr_en = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_rd_en = 1'b0;
  logic [31:0]  bus_rdata;
  logic [143:0] pins = '0;
  logic [15:0]  line_out;

  item_t       sb[$];
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [15:0] sel_m [4];
  logic [31:0] comp_m;

  always #2 clk = ~clk;

  exti_route_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .pin_in(pins), .line_out(line_out)
  );

  function automatic logic [15:0] exp_lines();
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      logic [3:0] c;
      c = sel_m[n/4][(n%4)*4 +: 4];
      r[n] = (c < 4'd9) ? pins[int'(c)*16 + n] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] model_read(logic [9:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a >= 10'h08 && a <= 10'h14) return {16'h0, sel_m[(a - 10'h08) >> 2]};
    if (a == 10'h20) return comp_m;
    return 32'h0;
  endfunction

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] obs;
      it  = sb.pop_front();
      obs = it.is_line ? {16'h0, line_out} : bus_rdata;
      n_tests++;
      if (obs !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.rq, obs, it.exp);
      end
    end
  end

  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
    if (a[1:0] == 2'b00 && a >= 10'h08 && a <= 10'h14) sel_m[(a - 10'h08) >> 2] = d[15:0];
    else if (a == 10'h20) comp_m = d;
  endtask

  task automatic read_chk(logic [9:0] a, string rq);
    @(posedge clk); #1;
    bus_addr = a; bus_rd_en = 1'b1;
    sb.push_back('{1'b0, model_read(a), rq});
    @(negedge clk); #1;
    bus_rd_en = 1'b0;
  endtask

  task automatic line_chk(string rq);
    @(posedge clk); #1;
    sb.push_back('{1'b1, {16'h0, exp_lines()}, rq});
    @(negedge clk); #1;
  endtask

  task automatic set_pattern(logic [15:0] seed);
    for (int p = 0; p < 9; p++) pins[p*16 +: 16] = seed ^ (16'h1357 * 16'(p + 1));
  endtask

  task automatic read_all_mapped(string rq);
    read_chk(10'h00, rq); read_chk(10'h04, rq);
    for (int i = 0; i < 4; i++) read_chk(10'(8 + 4*i), rq);
    read_chk(10'h20, rq);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) sel_m[i] = '0;
    comp_m = '0;
    set_pattern(16'hA5C3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset image, all lines on port 0
    read_all_mapped("R1");
    line_chk("R1");

    // R2: selection register keeps low half only
    bus_write(10'h08, 32'hFFFF_1234);
    read_chk(10'h08, "R2");
    // R3: field positions and port forwarding over several pin patterns
    bus_write(10'h0C, 32'h0000_5678);
    bus_write(10'h10, 32'hABCD_8012);
    bus_write(10'h14, 32'h0000_3456);
    line_chk("R3");
    set_pattern(16'h0F0F);
    line_chk("R3");
    set_pattern(16'hFFFF);
    line_chk("R3");

    // R5: all lines on port 2, toggle every other port
    for (int i = 0; i < 4; i++) bus_write(10'(8 + 4*i), 32'h0000_2222);
    pins = '0; pins[2*16 +: 16] = 16'hC3A5;
    line_chk("R5");
    for (int p = 0; p < 9; p++) if (p != 2) pins[p*16 +: 16] = 16'hFFFF;
    line_chk("R5");

    // R4: reserved codes 9..15 drive low with all pins high
    pins = '1;
    bus_write(10'h0C, 32'h0000_F9AB);
    bus_write(10'h08, 32'h0000_CDE8);
    line_chk("R4");

    // R6: remap and mode discard writes
    bus_write(10'h00, 32'hFFFF_FFFF);
    bus_write(10'h04, 32'h1234_5678);
    read_chk(10'h00, "R6");
    read_chk(10'h04, "R6");

    // R7: compensation register full width
    bus_write(10'h20, 32'hDEAD_BEEF);
    read_chk(10'h20, "R7");
    bus_write(10'h20, 32'h8000_0001);
    read_chk(10'h20, "R7");

    // R8: unmapped writes touch nothing, unmapped reads give zero
    bus_write(10'h18, 32'hFFFF_FFFF);
    bus_write(10'h24, 32'hFFFF_FFFF);
    bus_write(10'h3FC, 32'hFFFF_FFFF);
    bus_write(10'h09, 32'hFFFF_FFFF);
    read_all_mapped("R8");
    read_chk(10'h1C, "R8");
    read_chk(10'h3FC, "R8");
    read_chk(10'h0A, "R8");

    // R9: new code reaches the line only at the capturing edge
    set_pattern(16'h00FF);
    pins[0 +: 16] = 16'h0000; pins[16*5 +: 16] = 16'hFFFF;
    bus_write(10'h08, 32'h0000_0000);
    @(posedge clk); #1;
    bus_addr = 10'h08; bus_wdata = 32'h0000_5555; bus_wr_en = 1'b1;
    sb.push_back('{1'b1, {16'h0, exp_lines()}, "R9"});
    @(negedge clk); #1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
    sel_m[0] = 16'h5555;
    sb.push_back('{1'b1, {16'h0, exp_lines()}, "R9"});
    @(negedge clk); #1;

    // R10: no read strobe, data stays zero
    @(posedge clk); #1;
    bus_addr = 10'h20; bus_rd_en = 1'b0;
    sb.push_back('{1'b0, 32'h0, "R10"});
    @(negedge clk); #1;

    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule